// File: doc/BRIEF.md
# Dual-Domain Clock-Enable Divider and Gate

This block turns a single oscillator clock into two clock-enable strobes: a core strobe whose rate is set by a 3-bit divide code, and a peripheral strobe that always runs at the full oscillator rate. Both strobes are single-cycle enables in the oscillator domain, not gated clocks. Downstream logic runs on the oscillator clock and advances only in cycles where its enable is high.

Two low-power inputs gate the strobes differently. The sleep input (`pwr_down`) stops both strobes. The wait input (`idle`) stops only the core strobe. A register write port loads the divide code and a debug-comparator enable bit together in one write. The new divide code governs the core strobe from the very next cycle, with no handshake.

Top module: `dual_clk_enable_gen`

## Requirements
- R1: After reset the divide code is 0 (divide by 1) and `dbg_cmp_en` is 1. The first ungated cycle after reset drives `core_ce` high.
- R2: The divide code maps to a ratio as follows: 0 gives ÷1, 1 gives ÷2, 2 gives ÷4, 3 gives ÷8, 4 gives ÷16, 5 gives ÷32, 6 gives ÷1024, and 7 gives ÷2048. While ungated and with no write, `core_ce` pulses once every ratio cycles.
- R3: When `cfg_we` is high at a clock edge, `cfg_div` and `cfg_dbg` are loaded at that edge and the divide counter restarts. With ratio N, the first following `core_ce` pulse comes in the N-th cycle after the edge. For ratio 1 that is the first cycle after the edge.
- R4: `core_ce` is low in every cycle in which `pwr_down` or `idle` is high.
- R5: `periph_ce` equals the inverse of `pwr_down` in every cycle. The divide code has no effect on it.
- R6: `idle` has no effect on `periph_ce`.
- R7: `dbg_cmp_en` changes only on a write, where it takes the value of `cfg_dbg`.
- R8: While `pwr_down` or `idle` is high, the counter is held at zero. With ratio N, the first `core_ce` pulse after both bits clear comes in the N-th ungated cycle.
- R9: A write made while gated still loads the divide code. The new ratio applies when the core strobe resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_div | input | 3 | Divide code to load |
| cfg_dbg | input | 1 | Debug-comparator enable value to load |
| pwr_down | input | 1 | Sleep request; stops both strobes |
| idle | input | 1 | Wait request; stops the core strobe only |
| core_ce | output | 1 | Core clock-enable strobe |
| periph_ce | output | 1 | Peripheral clock-enable strobe |
| dbg_cmp_en | output | 1 | Breakpoint-comparator enable |

## Verification
A divide-code write can land in the same cycle that a core pulse is due, and it can also land in a cycle where a gating bit is raised. The random phase keeps writes and gating toggles frequent and independent so that both overlaps occur often. It also sets short ratios so that due pulses are common. In an overlap cycle the pulse is judged under the old code, because the new code only governs from the next cycle. The bench checks that the counter restarts and that a write made while gated sets the ratio seen after resume.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W    = 3;
  localparam int SHIFT_MAX = 11;
  localparam int CNT_W     = SHIFT_MAX;

  typedef logic [CODE_W-1:0] div_code_t;
  typedef logic [CNT_W-1:0]  div_cnt_t;

  // power-of-two exponent selected by each divide code
  function automatic int unsigned code_shift(input div_code_t code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 3;
      3'd4:    return 4;
      3'd5:    return 5;
      3'd6:    return 10;
      default: return 11;
    endcase
  endfunction

  // terminal count for a code: ratio minus one
  function automatic div_cnt_t code_last(input div_code_t code);
    div_cnt_t one;
    one = div_cnt_t'(1);
    return div_cnt_t'((one << code_shift(code)) - one);
  endfunction
endpackage

// File: rtl/clkdiv_cfg_regs.sv
module clkdiv_cfg_regs
  import clkdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  div_code_t div_in,
  input  logic      dbg_in,
  output div_code_t div_q,
  output logic      dbg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      dbg_q <= 1'b1;
    end else if (we) begin
      div_q <= div_in;
      dbg_q <= dbg_in;
    end
  end

  // R7: the enable bit moves only on a write
  a_r7_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(dbg_q));
  a_r3_div_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (div_q == $past(div_in)));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  logic      hold,
  input  div_code_t div_q,
  output logic      tick
);
  div_cnt_t cnt_q;
  div_cnt_t last;

  assign last = code_last(div_q);
  assign tick = (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || hold)  cnt_q <= '0;
    else if (tick)             cnt_q <= '0;
    else                       cnt_q <= cnt_q + div_cnt_t'(1);
  end

  // R3: a write restarts the count
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  // R8: gating parks the counter at zero
  a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));
  // R2: counter never passes the terminal count of a steady code
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(div_q) |-> (cnt_q <= last));
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_down,
  input  logic idle,
  output logic core_ce,
  output logic periph_ce
);
  assign core_ce   = tick & ~pwr_down & ~idle;
  assign periph_ce = ~pwr_down;

  // R4: no core strobe while either low-power bit is up
  a_r4_core_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down || idle) |-> !core_ce);
  // R6: wait mode leaves the peripheral strobe running
  a_r6_idle_periph: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !pwr_down) |-> periph_ce);
  // R5: sleep stops the peripheral strobe
  a_r5_pd_periph: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !periph_ce);
endmodule

// File: rtl/dual_clk_enable_gen.sv
module dual_clk_enable_gen
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_div,
  input  logic       cfg_dbg,
  input  logic       pwr_down,
  input  logic       idle,
  output logic       core_ce,
  output logic       periph_ce,
  output logic       dbg_cmp_en
);
  div_code_t div_q;
  logic      tick;
  logic      gated;

  assign gated = pwr_down | idle;

  clkdiv_cfg_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .div_in (cfg_div),
    .dbg_in (cfg_dbg),
    .div_q  (div_q),
    .dbg_q  (dbg_cmp_en)
  );

  clkdiv_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_we),
    .hold    (gated),
    .div_q   (div_q),
    .tick    (tick)
  );

  clkdiv_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .pwr_down  (pwr_down),
    .idle      (idle),
    .core_ce   (core_ce),
    .periph_ce (periph_ce)
  );

  // R1: divide-by-one default strobes every ungated cycle
  a_r1_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && !gated) |-> core_ce);
endmodule

// File: tb/dual_clk_enable_gen_tb.sv
module dual_clk_enable_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_div = 3'd0;
  logic cfg_dbg = 1'b0;
  logic pwr_down = 1'b0;
  logic idle = 1'b0;
  logic core_ce, periph_ce, dbg_cmp_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [2:0]  m_div;
  logic [10:0] m_cnt;
  logic        m_dbg;

  always #2 clk = ~clk;

  dual_clk_enable_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_dbg(cfg_dbg), .pwr_down(pwr_down), .idle(idle),
    .core_ce(core_ce), .periph_ce(periph_ce), .dbg_cmp_en(dbg_cmp_en)
  );

  function automatic int unsigned ratio_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;    3'd1: return 2;    3'd2: return 4;
      3'd3: return 8;    3'd4: return 16;   3'd5: return 32;
      3'd6: return 1024; default: return 2048;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one oscillator cycle: drive, compare, advance reference
  task automatic step(input logic we, input logic [2:0] dv, input logic db,
                      input logic pd, input logic id, output logic got_core);
    logic exp_core;
    @(negedge clk);
    cfg_we = we; cfg_div = dv; cfg_dbg = db; pwr_down = pd; idle = id;
    #1;
    exp_core = !pd && !id && (m_cnt == 11'(ratio_of(m_div) - 1));
    check((pd || id) ? "R4" : "R2", core_ce, exp_core);
    check(id ? "R6" : "R5", periph_ce, !pd);
    check("R7", dbg_cmp_en, m_dbg);
    got_core = core_ce;
    @(posedge clk);
    if (we || pd || id)                          m_cnt = '0;
    else if (m_cnt == 11'(ratio_of(m_div) - 1))  m_cnt = '0;
    else                                         m_cnt = m_cnt + 11'd1;
    if (we) begin m_div = dv; m_dbg = db; end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic c;
    int first;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_div = '0; m_cnt = '0; m_dbg = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", dbg_cmp_en, 1'b1);
    rst_n = 1'b1;
    // R1: first ungated cycle pulses
    step(0, 0, 0, 0, 0, c);
    check("R1", c, 1'b1);

    // R3: write code 6, first pulse 1024 cycles on
    step(1, 3'd6, 1, 0, 0, c);
    first = -1;
    for (int k = 0; k < 1100; k++) begin
      step(0, 0, 0, 0, 0, c);
      if (c && first < 0) first = k;
    end
    check_int("R3", first, 1023);

    // R2: each code's spacing
    for (int code = 0; code < 8; code++) begin
      int prev, gap;
      step(1, 3'(code), 1, 0, 0, c);
      prev = -1; gap = -1;
      for (int k = 0; k < 4200; k++) begin
        step(0, 0, 0, 0, 0, c);
        if (c) begin
          if (prev >= 0 && gap < 0) gap = k - prev;
          prev = k;
        end
        if (gap >= 0) break;
      end
      check_int("R2", gap, int'(ratio_of(3'(code))));
    end

    // R9 and R8: write while gated, resume with new ratio
    step(0, 0, 0, 0, 1, c);
    step(1, 3'd3, 0, 0, 1, c);
    step(0, 0, 0, 1, 1, c);
    check("R5", periph_ce, 1'b0);
    step(0, 0, 0, 0, 1, c);
    check("R6", periph_ce, 1'b1);
    first = -1;
    for (int k = 0; k < 20; k++) begin
      step(0, 0, 0, 0, 0, c);
      if (c && first < 0) first = k;
    end
    check_int("R8", first, 7);
    check_int("R9", first + 1, 8);

    // random: short codes, frequent writes and gating
    for (int n = 0; n < 30000; n++) begin
      logic we, pd, id, db;
      logic [2:0] dv;
      we = ($urandom % 16) == 0;
      dv = 3'($urandom % 6);
      db = 1'($urandom);
      pd = ($urandom % 12) == 0;
      id = ($urandom % 10) == 0;
      step(we, dv, db, pd, id, c);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule